// File: doc/BRIEF.md
# Half-Word Multiply-Add Execution Unit

This unit performs one integer operation of a shader-style processor: it takes one 16-bit half of operand A and one 16-bit half of operand B and multiplies them. It can move the product up by 16 bit positions. It then adds operand C after conditioning C according to a 3-bit mode field. Optionally, it replaces the upper half of the sum with the low half of the unmodified B value. The operands arrive already fetched. The caller presents the 64-bit instruction word and a 2-bit form code, which tells the unit whether B came from a register, an immediate, or a constant bank, and whether C came from a constant bank.

The result is registered once. It is qualified by `in_valid` and comes with an error flag. Signed operands and the special-function C mode are not implemented. Requesting any of them raises the error flag and forces a zero result. Note that bit 52 is both the top bit of the C-mode field and the B-half select. The upper half of B is therefore only ever used together with the B-fold C mode (mode 4).

Top module: `halfmac_unit`

## Requirements
- R1: Bit 53 of `ctrl` selects the A multiplicand: when it is 1, the multiplicand is `opd_a[31:16]`; when it is 0, the multiplicand is `opd_a[15:0]`.
- R2: Bit 52 of `ctrl` selects the B multiplicand in the same way, using the upper half when it is 1. In the immediate form (`form` = 1), B is `ctrl[35:20]` zero-extended, and `opd_b` has no effect on the result.
- R3: When bit 36 of `ctrl` is 1, the 32-bit product of the two halves is shifted left by 16 before the addition.
- R4: The C-mode field `ctrl[52:50]` conditions C as follows. Mode 0 passes C unchanged. Mode 1 keeps `C[15:0]`. Mode 2 uses C shifted right by 16. Mode 4 uses C plus the original 32-bit B shifted left by 16.
- R5: C-mode codes 3, 5, 6 and 7 set `err` and force `result` to 0 for that operation.
- R6: If sign bit 48 (A) or sign bit 49 (B) of `ctrl` is 1, the unit sets `err` and forces `result` to 0.
- R7: When merge is active, the result is the low 16 bits of (product + conditioned C) ORed with the original B shifted left by 16. The bit that enables merge depends on the form. Form 2 (B from a constant bank) uses bit 56. Form 0 (register-register) and form 1 (immediate) use bit 37. Form 3 (C from a constant bank) never merges.
- R8: All shifts and the addition wrap modulo 2^32, with no carry or overflow output.
- R9: `out_valid` equals `in_valid` delayed by one cycle. `result` and `err` load only in cycles where `in_valid` is 1, and hold their values otherwise.
- R10: A synchronous active-low reset clears `out_valid`, `err` and `result` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| form | input | 2 | Source form: 0 reg-reg, 1 immediate, 2 B from constant bank, 3 C from constant bank |
| ctrl | input | 64 | Instruction word control fields |
| opd_a | input | 32 | Operand A value |
| opd_b | input | 32 | Operand B value (unused in immediate form) |
| opd_c | input | 32 | Operand C value |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 32 | Registered result |
| err | output | 1 | Unsupported sign or C-mode request |

## Verification
A wrong half select, shift or C-mode path in the combinational stages shows up at `result` on the cycle right after the offending operation is accepted. Each such fault corrupts a specific bit pattern, so the vectors use distinct values in the upper and lower halves of every operand. A wrong merge-bit decode appears as an upper half that does or does not carry B's low half, depending on the form. A fault in the output register instead shows up as a result that changes during idle cycles, or as a valid strobe that is off by one cycle.

// File: rtl/halfmac_pkg.sv
// Package: shared encodings and instruction-word bit positions for the
// half-word multiply-add unit. Assumes a 64-bit instruction word.
package halfmac_pkg;

    // Operand source form presented by the issue logic
    typedef enum logic [1:0] {
        FORM_RR     = 2'd0,
        FORM_IMM    = 2'd1,
        FORM_BCONST = 2'd2,
        FORM_CCONST = 2'd3
    } form_e;

    // C conditioning modes (field ctrl[52:50])
    typedef enum logic [2:0] {
        CM_PASS  = 3'd0,
        CM_LO    = 3'd1,
        CM_HI    = 3'd2,
        CM_SFU   = 3'd3,
        CM_BFOLD = 3'd4,
        CM_R5    = 3'd5,
        CM_R6    = 3'd6,
        CM_R7    = 3'd7
    } cmode_e;

    localparam int CTRL_W      = 64;
    localparam int BIT_IMM_LO  = 20;
    localparam int IMM_W       = 16;
    localparam int BIT_PSHIFT  = 36;
    localparam int BIT_MRG_LO  = 37;
    localparam int BIT_SIGN_A  = 48;
    localparam int BIT_SIGN_B  = 49;
    localparam int BIT_MODE_LO = 50;
    localparam int MODE_W      = 3;
    localparam int BIT_HI_B    = 52;
    localparam int BIT_HI_A    = 53;
    localparam int BIT_MRG_HI  = 56;

endpackage

// File: rtl/hm_src_route.sv
// Module: hm_src_route
// Resolves the effective 32-bit B value and the merge enable from the form
// code. Assumes the immediate is zero-extended and that form 3 never merges.
module hm_src_route
    import halfmac_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  form_e         form,
    input  logic [IMM_W-1:0] imm,
    input  logic          mrg_lo_bit,
    input  logic          mrg_hi_bit,
    input  logic [DW-1:0] opd_b,
    output logic [DW-1:0] b_full,
    output logic          merge_en
);
    localparam int PAD_W = DW - IMM_W;

    // Pick B: immediate for the immediate form, fetched operand otherwise
    always_comb begin
        if (form == FORM_IMM) begin
            b_full = {{PAD_W{1'b0}}, imm};
        end else begin
            b_full = opd_b;
        end
    end

    // Decode which instruction bit controls merge for this form
    always_comb begin
        unique case (form)
            FORM_BCONST: merge_en = mrg_hi_bit;
            FORM_CCONST: merge_en = 1'b0;
            default:     merge_en = mrg_lo_bit;
        endcase
    end

    AST_CCONST_NO_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        (form == FORM_CCONST) |-> !merge_en); // R7
    AST_IMM_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (form == FORM_IMM) |-> (b_full[DW-1:IMM_W] == '0)); // R2

endmodule

// File: rtl/hm_product.sv
// Module: hm_product
// Selects one half of each multiplicand, forms the unsigned product and
// optionally shifts it up by one half-word. Assumes unsigned operands.
module hm_product #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] opd_a,
    input  logic [DW-1:0] b_full,
    input  logic          hi_a,
    input  logic          hi_b,
    input  logic          pshift,
    output logic [DW-1:0] prod
);
    localparam int HW = DW / 2;
    localparam int NOPS = 2;

    logic [DW-1:0] src   [NOPS];
    logic          sel_hi[NOPS];
    logic [HW-1:0] half  [NOPS];
    logic [DW-1:0] mul;

    assign src[0]    = opd_a;
    assign src[1]    = b_full;
    assign sel_hi[0] = hi_a;
    assign sel_hi[1] = hi_b;

    // One half-word selector per multiplicand
    for (genvar g = 0; g < NOPS; g++) begin : g_half
        // Choose upper or lower half of this operand
        always_comb begin
            half[g] = sel_hi[g] ? src[g][DW-1:HW] : src[g][HW-1:0];
        end
    end

    // Unsigned 16x16 multiply into a full-width product
    always_comb begin
        mul = {{HW{1'b0}}, half[0]} * {{HW{1'b0}}, half[1]};
    end

    // Optional half-word shift, wrapping at the data width
    always_comb begin
        prod = pshift ? {mul[HW-1:0], {HW{1'b0}}} : mul;
    end

    AST_SHIFT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pshift |-> (prod[HW-1:0] == '0)); // R3
    AST_ZERO_HALF_ZERO_PROD: assert property (@(posedge clk) disable iff (!rst_n)
        ((hi_a ? opd_a[DW-1:HW] : opd_a[HW-1:0]) == '0) |-> (prod == '0)); // R1

endmodule

// File: rtl/hm_cond_c.sv
// Module: hm_cond_c
// Conditions operand C according to the mode field and flags unsupported
// modes. Assumes the B-fold mode uses the original full-width B.
module hm_cond_c
    import halfmac_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cmode_e        mode,
    input  logic [DW-1:0] opd_c,
    input  logic [DW-1:0] b_full,
    output logic [DW-1:0] c_cond,
    output logic          bad_mode
);
    localparam int HW = DW / 2;

    // Produce the conditioned C and the unsupported-mode flag
    always_comb begin
        bad_mode = 1'b0;
        c_cond   = '0;
        unique case (mode)
            CM_PASS:  c_cond = opd_c;
            CM_LO:    c_cond = {{HW{1'b0}}, opd_c[HW-1:0]};
            CM_HI:    c_cond = {{HW{1'b0}}, opd_c[DW-1:HW]};
            CM_BFOLD: c_cond = opd_c + {b_full[HW-1:0], {HW{1'b0}}};
            default:  bad_mode = 1'b1;
        endcase
    end

    AST_LO_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == CM_LO) || (mode == CM_HI)) |-> (c_cond[DW-1:HW] == '0)); // R4
    AST_SUPPORTED_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == CM_PASS) || (mode == CM_LO) || (mode == CM_HI) || (mode == CM_BFOLD))
        |-> !bad_mode); // R5
    AST_UNSUPPORTED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == CM_SFU) || (mode[2] && (mode[1:0] != 2'b00))) |-> bad_mode); // R5

endmodule

// File: rtl/halfmac_unit.sv
// Module: halfmac_unit (top)
// Half-word multiply-add with C conditioning and B merge, one register
// stage. Assumes operands are already fetched and only unsigned use.
module halfmac_unit
    import halfmac_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [1:0]  form,
    input  logic [63:0] ctrl,
    input  logic [31:0] opd_a,
    input  logic [31:0] opd_b,
    input  logic [31:0] opd_c,
    output logic        out_valid,
    output logic [31:0] result,
    output logic        err
);
    localparam int DW = 32;
    localparam int HW = DW / 2;

    form_e         form_q;
    cmode_e        mode;
    logic [DW-1:0] b_full;
    logic          merge_en;
    logic [DW-1:0] prod;
    logic [DW-1:0] c_cond;
    logic          bad_mode;
    logic          sign_req;
    logic [DW-1:0] sum;
    logic [DW-1:0] res_n;
    logic          err_n;
    logic          unused_ctrl_bits;

    assign form_q   = form_e'(form);
    assign mode     = cmode_e'(ctrl[BIT_MODE_LO +: MODE_W]);
    assign sign_req = ctrl[BIT_SIGN_A] | ctrl[BIT_SIGN_B];
    assign unused_ctrl_bits = ^{ctrl[63:57], ctrl[55:54], ctrl[47:38], ctrl[19:0]};

    hm_src_route #(.DW(DW)) route_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .form       (form_q),
        .imm        (ctrl[BIT_IMM_LO +: IMM_W]),
        .mrg_lo_bit (ctrl[BIT_MRG_LO]),
        .mrg_hi_bit (ctrl[BIT_MRG_HI]),
        .opd_b      (opd_b),
        .b_full     (b_full),
        .merge_en   (merge_en)
    );

    hm_product #(.DW(DW)) prod_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .opd_a  (opd_a),
        .b_full (b_full),
        .hi_a   (ctrl[BIT_HI_A]),
        .hi_b   (ctrl[BIT_HI_B]),
        .pshift (ctrl[BIT_PSHIFT]),
        .prod   (prod)
    );

    hm_cond_c #(.DW(DW)) cond_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .opd_c    (opd_c),
        .b_full   (b_full),
        .c_cond   (c_cond),
        .bad_mode (bad_mode)
    );

    // Wrapping add of product and conditioned C
    always_comb begin
        sum = prod + c_cond;
    end

    // Apply merge, then force zero on any error request
    always_comb begin
        err_n = bad_mode | sign_req;
        if (err_n) begin
            res_n = '0;
        end else if (merge_en) begin
            res_n = {b_full[HW-1:0], sum[HW-1:0]};
        end else begin
            res_n = sum;
        end
    end

    // Output register: valid every cycle, data and error only on accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            err       <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= res_n;
                err    <= err_n;
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R9
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(err))); // R9
    AST_ERR_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (result == '0)); // R5
    AST_SIGN_FLAGS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (ctrl[BIT_SIGN_A] || ctrl[BIT_SIGN_B])) |=> err); // R6
    AST_MERGE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && merge_en && !err_n) |=> (result[DW-1:HW] == $past(b_full[HW-1:0]))); // R7
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !err && (result == '0))); // R10

endmodule

// File: tb/halfmac_unit_tb_top.sv
// Bench: vector table walked by one loop, then directed reset/idle tests.
module halfmac_unit_tb_top;

    typedef struct packed {
        logic [1:0]  form;
        logic [63:0] ctrl;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] c;
        logic [31:0] exp_res;
        logic        exp_err;
    } vec_t;

    localparam int NV = 18;
    // ctrl bits: 36 shift, 37 merge(rr/imm), 48/49 sign, 52:50 mode,
    // 52 B-half, 53 A-half, 56 merge(B const), 35:20 immediate
    localparam vec_t TAB [NV] = '{
        '{2'd0, 64'h0000_0000_0000_0000, 32'h0003_0005, 32'h0007_0002, 32'h0000_0010, 32'h0000_001A, 1'b0}, // R1 low A, R4 mode0
        '{2'd0, 64'h0020_0000_0000_0000, 32'h0003_0005, 32'h0007_0002, 32'h0000_0010, 32'h0000_0016, 1'b0}, // R1 high A
        '{2'd0, 64'h0010_0000_0000_0000, 32'h0003_0005, 32'h0007_0002, 32'h0000_0010, 32'h0002_0033, 1'b0}, // R2 high B, R4 mode4
        '{2'd0, 64'h0000_0010_0000_0000, 32'h0000_0003, 32'h0000_0004, 32'h0000_0001, 32'h000C_0001, 1'b0}, // R3 shift
        '{2'd0, 64'h0000_0010_0000_0000, 32'h0000_FFFF, 32'h0000_FFFF, 32'hFFFF_0000, 32'h0000_0000, 1'b0}, // R8 wrap
        '{2'd0, 64'h0004_0000_0000_0000, 32'h0000_0002, 32'h0000_0003, 32'hABCD_1234, 32'h0000_123A, 1'b0}, // R4 mode1
        '{2'd0, 64'h0008_0000_0000_0000, 32'h0000_0002, 32'h0000_0003, 32'hABCD_1234, 32'h0000_ABD3, 1'b0}, // R4 mode2
        '{2'd1, 64'h0000_0001_2340_0000, 32'h0000_0002, 32'hDEAD_BEEF, 32'h0000_0000, 32'h0000_2468, 1'b0}, // R2 imm
        '{2'd0, 64'h0000_0020_0000_0000, 32'h0000_0010, 32'h0005_0003, 32'h0000_FFF0, 32'h0003_0020, 1'b0}, // R7 rr merge
        '{2'd2, 64'h0100_0000_0000_0000, 32'h0000_0010, 32'h0005_0003, 32'h0000_FFF0, 32'h0003_0020, 1'b0}, // R7 bconst bit56
        '{2'd2, 64'h0000_0020_0000_0000, 32'h0000_0010, 32'h0005_0003, 32'h0000_FFF0, 32'h0001_0020, 1'b0}, // R7 bconst ignores 37
        '{2'd3, 64'h0100_0020_0000_0000, 32'h0000_0010, 32'h0005_0003, 32'h0000_FFF0, 32'h0001_0020, 1'b0}, // R7 cconst no merge
        '{2'd1, 64'h0000_0020_0AB0_0000, 32'h0000_0001, 32'h1111_2222, 32'h0001_0000, 32'h00AB_00AB, 1'b0}, // R7 imm merge
        '{2'd0, 64'h000C_0000_0000_0000, 32'h0000_0002, 32'h0000_0003, 32'h0000_0004, 32'h0000_0000, 1'b1}, // R5 mode3
        '{2'd0, 64'h0018_0000_0000_0000, 32'h0000_0002, 32'h0000_0003, 32'h0000_0004, 32'h0000_0000, 1'b1}, // R5 mode6
        '{2'd0, 64'h0001_0000_0000_0000, 32'h0000_0002, 32'h0000_0003, 32'h0000_0004, 32'h0000_0000, 1'b1}, // R6 sign A
        '{2'd0, 64'h0002_0000_0000_0000, 32'h0000_0002, 32'h0000_0003, 32'h0000_0004, 32'h0000_0000, 1'b1}, // R6 sign B
        '{2'd0, 64'h0010_0020_0000_0000, 32'h0000_0001, 32'h0002_0003, 32'h0000_0005, 32'h0003_0007, 1'b0}  // R7 merge + mode4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  form = 2'd0;
    logic [63:0] ctrl = '0;
    logic [31:0] opd_a = '0;
    logic [31:0] opd_b = '0;
    logic [31:0] opd_c = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    halfmac_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .form      (form),
        .ctrl      (ctrl),
        .opd_a     (opd_a),
        .opd_b     (opd_b),
        .opd_c     (opd_c),
        .out_valid (out_valid),
        .result    (result),
        .err       (err)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        form  = v.form;
        ctrl  = v.ctrl;
        opd_a = v.a;
        opd_b = v.b;
        opd_c = v.c;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 out_valid", {31'd0, out_valid}, 32'd0);
        check("R10 result", result, 32'd0);
        check("R10 err", {31'd0, err}, 32'd0);
        rst_n = 1'b1;

        // Table walk: drive at a falling edge, sample at the next one
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(TAB[i]);
            in_valid = 1'b1;
            @(negedge clk);
            check($sformatf("vec%0d valid R9", i), {31'd0, out_valid}, 32'd1);
            check($sformatf("vec%0d result", i), result, TAB[i].exp_res);
            check($sformatf("vec%0d err", i), {31'd0, err}, {31'd0, TAB[i].exp_err});
        end

        // R2: immediate form ignores opd_b
        drive(TAB[7]);
        opd_b = 32'h0F0F_0F0F;
        @(negedge clk);
        check("R2 imm opd_b ignored", result, 32'h0000_2468);

        // R9: idle cycles hold result and err, valid drops
        in_valid = 1'b0;
        drive(TAB[0]);
        @(negedge clk);
        check("R9 valid drops", {31'd0, out_valid}, 32'd0);
        check("R9 result held", result, 32'h0000_2468);
        drive(TAB[13]);
        @(negedge clk);
        check("R9 err held", {31'd0, err}, 32'd0);
        check("R9 result held 2", result, 32'h0000_2468);

        // R5/R9: error then good op clears err
        in_valid = 1'b1;
        @(negedge clk);
        check("R5 err set", {31'd0, err}, 32'd1);
        drive(TAB[5]);
        @(negedge clk);
        check("R5 err cleared", {31'd0, err}, 32'd0);
        check("R4 after err", result, 32'h0000_123A);

        // R9: exactly one-cycle latency on a single pulse
        in_valid = 1'b0;
        @(negedge clk);
        drive(TAB[3]);
        in_valid = 1'b1;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        check("R9 latency valid", {31'd0, out_valid}, 32'd1);
        check("R9 latency result", result, 32'h000C_0001);
        @(negedge clk);
        @(negedge clk);
        check("R9 pulse ends", {31'd0, out_valid}, 32'd0);

        // R10: mid-stream reset clears everything
        drive(TAB[13]);
        in_valid = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 valid cleared", {31'd0, out_valid}, 32'd0);
        check("R10 err cleared", {31'd0, err}, 32'd0);
        check("R10 result cleared", result, 32'd0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule